// File: doc/BRIEF.md
# Linked Command List Processor

This block executes a chain of command blocks stored in a memory of 16-bit words. Memory addresses are byte addresses, and each access carries one word through a request/acknowledge port. A start pulse activates the unit. The unit then visits each block in turn. For every block it marks the block busy, fetches the command word, performs the action that the opcode selects and marks the block complete. It then follows the block's link to the next block.

Most actions take place inside the block itself. These are loading a six-byte station address, loading a configuration array, reporting link state, or completing at once. Frame transmission and multicast filter loading are handed to neighbouring logic. The block raises a one-cycle strobe with the block pointer and waits for a done pulse. Control bits in the command word can end the chain, park the unit in a suspended state, or request an interrupt. A later start pulse resumes a suspended chain at its saved link.

Top module: `clw_cmd_walker`

## Requirements
- R1: After reset the unit state is idle (code 0), the event flag, interrupt and strobes are low, no memory request is made, and the address and configuration arrays read zero.
- R2: A memory request holds its address, direction and write data stable until acknowledged; words are 16 bits at even byte addresses, and a 32-bit link is read as the low word at block+4, then the high word at block+6.
- R3: For every block the unit writes 0x4000 to block+0, reads the command word at block+2, performs the action, writes 0xA000 to block+0, then reads the link.
- R4: Command bits 2:0 select the action; codes 0, 6 and 7 perform nothing else, and code 1 reads words at block+8, +10 and +12 into address bytes 0..5, with the byte at the even address in word bits 7:0.
- R5: Code 2 takes a count from bits 3:0 of the word at block+8, clamped to the range 4 to CFG_BYTES (14), and loads that many bytes starting at block+8 into configuration entries 0 upward; higher entries keep their value.
- R6: After each configure load, entry 10 is raised to 5 if below 5, and entry 13 has its low six bits forced to one.
- R7: Code 5 writes 0x8000 (link up) or 0x0000 (link down) to block+8 and 0x0000 to block+10.
- R8: Code 4 pulses the transmit strobe and code 3 the multicast strobe, each for one cycle with the block pointer presented; completion is written only after the done input pulses.
- R9: A link of 0 or 0xFFFFFFFF, or command bit 15, ends the chain; the unit then returns to idle (code 0).
- R10: Command bit 14 stops the walk after that block with the unit in suspended state (code 1); a start pulse while the saved link is non-null resumes there and ignores the head input.
- R11: When command bit 13 is set, the event flag is set and the interrupt output pulses for one cycle; when it is clear, the flag is cleared.
- R12: A start pulse with a null saved pointer loads the head input; a null head makes no memory access and the unit returns to idle; start pulses during a walk have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or resume pulse |
| head_ptr_i | input | 32 | First block address, used when the saved pointer is null |
| link_up_i | input | 1 | Link state for the report command |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write when high, read when low |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| tx_start_o | output | 1 | Transmit hand-off strobe |
| mc_start_o | output | 1 | Multicast hand-off strobe |
| blk_ptr_o | output | 32 | Address of the block being executed |
| xfer_done_i | input | 1 | Hand-off done pulse |
| ia_o | output | 48 | Station address, byte k in bits 8k+7:8k |
| cfg_o | output | 112 | Configuration array, entry k in bits 8k+7:8k |
| cu_state_o | output | 2 | Unit state: 0 idle, 1 suspended, 2 active |
| cx_flag_o | output | 1 | Command-complete event flag |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The assertions check on every cycle that the memory request holds stable until acknowledged. They also check that accesses occur only while the unit is active and that the two hand-off strobes are single, exclusive pulses. An interrupt must never appear without the event flag, and the unit state must never take the unused code. The order of the accesses, the configure clamp and fix-ups, the link-report values, chain termination, and resumption after suspend all depend on the contents of memory. Only the bench scenarios can show these, by comparing each access against a behavioural model of the chain.

// File: rtl/clw_pkg.sv
package clw_pkg;
  localparam int unsigned PTR_W = 32;
  localparam int unsigned WORD_W = 16;
  localparam logic [PTR_W-1:0] PTR_NULL = '1;
  localparam logic [WORD_W-1:0] ST_BUSY = 16'h4000;
  localparam logic [WORD_W-1:0] ST_DONE = 16'hA000;
  localparam logic [WORD_W-1:0] LINK_UP_WORD = 16'h8000;
  localparam int unsigned MINLEN_IDX = 10;
  localparam logic [7:0] MINLEN_VAL = 8'd5;
  localparam int unsigned ONES_IDX = 13;
  localparam logic [7:0] ONES_MASK = 8'h3F;
  localparam int unsigned CFG_MIN_CNT = 4;

  typedef enum logic [1:0] {
    CU_IDLE   = 2'd0,
    CU_SUSP   = 2'd1,
    CU_ACTIVE = 2'd2
  } cu_state_e;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_IA   = 3'd1,
    OP_CFG  = 3'd2,
    OP_MC   = 3'd3,
    OP_TX   = 3'd4,
    OP_LINK = 3'd5,
    OP_DUMP = 3'd6,
    OP_DIAG = 3'd7
  } opcode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_WBUSY, S_RCMD, S_CFGCNT, S_RDATA, S_FIX,
    S_LNK_LO, S_LNK_HI, S_HSTART, S_HWAIT, S_WDONE, S_RLNK_LO,
    S_RLNK_HI, S_NEXT
  } walk_state_e;
endpackage

// File: rtl/clw_ptr_unit.sv
module clw_ptr_unit
  import clw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_head_i,
  input  logic [PTR_W-1:0] head_i,
  input  logic             lo_we_i,
  input  logic             hi_we_i,
  input  logic [WORD_W-1:0] rdata_i,
  input  logic             eol_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             null_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic [WORD_W-1:0] lo_q;
  logic [PTR_W-1:0]  link_w;

  assign link_w = {rdata_i, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= PTR_NULL;
      lo_q  <= '0;
    end else begin
      if (lo_we_i) lo_q <= rdata_i;
      if (load_head_i) ptr_q <= head_i;
      else if (hi_we_i) ptr_q <= (eol_i || link_w == '0) ? PTR_NULL : link_w;
    end
  end

  assign ptr_o  = ptr_q;
  assign null_o = (ptr_q == PTR_NULL) || (ptr_q == '0);
endmodule

// File: rtl/clw_byte_bank.sv
module clw_byte_bank
  import clw_pkg::*;
#(
  parameter int unsigned N_BYTES = 6,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned LIM_W   = 5,
  parameter bit          FIXUP   = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   word_idx_i,
  input  logic [WORD_W-1:0]  wdata_i,
  input  logic [LIM_W-1:0]   limit_i,
  input  logic               fix_i,
  output logic [8*N_BYTES-1:0] bytes_o
);
  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    logic [7:0] q;
    logic [7:0] fixed;
    logic       hit;

    assign hit = wr_i && (int'(word_idx_i) == b / 2) && (int'(limit_i) > b);

    if (FIXUP && b == MINLEN_IDX) begin : g_minlen
      assign fixed = (q < MINLEN_VAL) ? MINLEN_VAL : q;
    end else if (FIXUP && b == ONES_IDX) begin : g_ones
      assign fixed = q | ONES_MASK;
    end else begin : g_keep
      assign fixed = q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (hit) q <= (b % 2 == 1) ? wdata_i[15:8] : wdata_i[7:0];
      else if (fix_i) q <= fixed;
    end

    assign bytes_o[8*b +: 8] = q;
  end
endmodule

// File: rtl/clw_cmd_walker.sv
module clw_cmd_walker
  import clw_pkg::*;
#(
  parameter int unsigned CFG_BYTES = 14,
  parameter int unsigned IA_BYTES  = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [31:0]            head_ptr_i,
  input  logic                   link_up_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [31:0]            mem_addr_o,
  output logic [15:0]            mem_wdata_o,
  input  logic [15:0]            mem_rdata_i,
  input  logic                   mem_ack_i,
  output logic                   tx_start_o,
  output logic                   mc_start_o,
  output logic [31:0]            blk_ptr_o,
  input  logic                   xfer_done_i,
  output logic [8*IA_BYTES-1:0]  ia_o,
  output logic [8*CFG_BYTES-1:0] cfg_o,
  output logic [1:0]             cu_state_o,
  output logic                   cx_flag_o,
  output logic                   irq_o
);
  localparam int unsigned IA_WORDS  = (IA_BYTES + 1) / 2;
  localparam int unsigned CFG_WORDS = (CFG_BYTES + 1) / 2;
  localparam int unsigned MAX_WORDS = (IA_WORDS > CFG_WORDS) ? IA_WORDS : CFG_WORDS;
  localparam int unsigned IDX_W     = $clog2(MAX_WORDS + 1);
  localparam int unsigned CNT_W     = $clog2(CFG_BYTES + 16);
  localparam int unsigned DATA_OFS  = 8;

  walk_state_e state_q;
  cu_state_e   cu_q;
  opcode_e     op_q;
  logic        eol_q, susp_q, intr_q;
  logic        cx_q, irq_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic [CNT_W-1:0] cfg_n_q;

  logic [PTR_W-1:0] ptr;
  logic             ptr_null;
  logic [PTR_W-1:0] off;
  logic             ack;
  logic [CNT_W-1:0] cfg_cnt_d;
  logic [IDX_W-1:0] cfg_last_d;
  logic             ia_wr, cfg_wr, cfg_fix;
  logic [CNT_W-1:0] cfg_limit;

  assign ack = mem_req_o && mem_ack_i;

  // count nibble clamped to [CFG_MIN_CNT, CFG_BYTES]
  always_comb begin
    int unsigned n;
    n = int'(mem_rdata_i[3:0]);
    if (n < CFG_MIN_CNT) n = CFG_MIN_CNT;
    if (n > CFG_BYTES) n = CFG_BYTES;
    cfg_cnt_d  = CNT_W'(n);
    cfg_last_d = IDX_W'((n + 1) / 2 - 1);
  end

  clw_ptr_unit u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_head_i (state_q == S_IDLE && start_i && ptr_null),
    .head_i      (head_ptr_i),
    .lo_we_i     (state_q == S_RLNK_LO && ack),
    .hi_we_i     (state_q == S_RLNK_HI && ack),
    .rdata_i     (mem_rdata_i),
    .eol_i       (eol_q),
    .ptr_o       (ptr),
    .null_o      (ptr_null)
  );

  assign ia_wr     = ack && state_q == S_RDATA && op_q == OP_IA;
  assign cfg_wr    = ack && (state_q == S_CFGCNT || (state_q == S_RDATA && op_q == OP_CFG));
  assign cfg_fix   = state_q == S_FIX;
  assign cfg_limit = (state_q == S_CFGCNT) ? cfg_cnt_d : cfg_n_q;

  clw_byte_bank #(
    .N_BYTES (IA_BYTES), .IDX_W (IDX_W), .LIM_W (CNT_W), .FIXUP (1'b0)
  ) u_ia_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ia_wr),
    .word_idx_i (idx_q),
    .wdata_i    (mem_rdata_i),
    .limit_i    (CNT_W'(IA_BYTES)),
    .fix_i      (1'b0),
    .bytes_o    (ia_o)
  );

  clw_byte_bank #(
    .N_BYTES (CFG_BYTES), .IDX_W (IDX_W), .LIM_W (CNT_W), .FIXUP (1'b1)
  ) u_cfg_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cfg_wr),
    .word_idx_i (idx_q),
    .wdata_i    (mem_rdata_i),
    .limit_i    (cfg_limit),
    .fix_i      (cfg_fix),
    .bytes_o    (cfg_o)
  );

  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    off         = '0;
    unique case (state_q)
      S_WBUSY:   begin mem_we_o = 1'b1; mem_wdata_o = ST_BUSY; end
      S_RCMD:    off = PTR_W'(2);
      S_CFGCNT,
      S_RDATA:   off = PTR_W'(DATA_OFS) + PTR_W'({idx_q, 1'b0});
      S_LNK_LO:  begin
        mem_we_o    = 1'b1;
        off         = PTR_W'(DATA_OFS);
        mem_wdata_o = link_up_i ? LINK_UP_WORD : '0;
      end
      S_LNK_HI:  begin mem_we_o = 1'b1; off = PTR_W'(DATA_OFS + 2); end
      S_WDONE:   begin mem_we_o = 1'b1; mem_wdata_o = ST_DONE; end
      S_RLNK_LO: off = PTR_W'(4);
      S_RLNK_HI: off = PTR_W'(6);
      default:   mem_req_o = 1'b0;
    endcase
  end

  assign mem_addr_o = ptr + off;
  assign tx_start_o = state_q == S_HSTART && op_q == OP_TX;
  assign mc_start_o = state_q == S_HSTART && op_q == OP_MC;
  assign blk_ptr_o  = ptr;
  assign cu_state_o = cu_q;
  assign cx_flag_o  = cx_q;
  assign irq_o      = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cu_q    <= CU_IDLE;
      op_q    <= OP_NOP;
      eol_q   <= 1'b0;
      susp_q  <= 1'b0;
      intr_q  <= 1'b0;
      cx_q    <= 1'b0;
      irq_q   <= 1'b0;
      idx_q   <= '0;
      last_q  <= '0;
      cfg_n_q <= '0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          cu_q    <= CU_ACTIVE;
          state_q <= S_CHECK;
        end
        S_CHECK: if (ptr_null) begin
          cu_q    <= CU_IDLE;
          state_q <= S_IDLE;
        end else begin
          state_q <= S_WBUSY;
        end
        S_WBUSY: if (ack) state_q <= S_RCMD;
        S_RCMD: if (ack) begin
          op_q   <= opcode_e'(mem_rdata_i[2:0]);
          eol_q  <= mem_rdata_i[15];
          susp_q <= mem_rdata_i[14];
          intr_q <= mem_rdata_i[13];
          idx_q  <= '0;
          last_q <= IDX_W'(IA_WORDS - 1);
          unique case (opcode_e'(mem_rdata_i[2:0]))
            OP_IA:        state_q <= S_RDATA;
            OP_CFG:       state_q <= S_CFGCNT;
            OP_LINK:      state_q <= S_LNK_LO;
            OP_TX, OP_MC: state_q <= S_HSTART;
            default:      state_q <= S_WDONE;
          endcase
        end
        S_CFGCNT: if (ack) begin
          cfg_n_q <= cfg_cnt_d;
          last_q  <= cfg_last_d;
          idx_q   <= IDX_W'(1);
          state_q <= S_RDATA;
        end
        S_RDATA: if (ack) begin
          if (idx_q == last_q) state_q <= (op_q == OP_CFG) ? S_FIX : S_WDONE;
          else idx_q <= idx_q + IDX_W'(1);
        end
        S_FIX:     state_q <= S_WDONE;
        S_LNK_LO:  if (ack) state_q <= S_LNK_HI;
        S_LNK_HI:  if (ack) state_q <= S_WDONE;
        S_HSTART:  state_q <= S_HWAIT;
        S_HWAIT:   if (xfer_done_i) state_q <= S_WDONE;
        S_WDONE:   if (ack) state_q <= S_RLNK_LO;
        S_RLNK_LO: if (ack) state_q <= S_RLNK_HI;
        S_RLNK_HI: if (ack) state_q <= S_NEXT;
        S_NEXT: begin
          cx_q  <= intr_q;
          irq_q <= intr_q;
          if (susp_q) begin
            cu_q    <= CU_SUSP;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_CHECK;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clw_cmd_walker_chk.sv
module clw_cmd_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [15:0] mem_wdata_o,
  input logic        mem_ack_i,
  input logic        tx_start_o,
  input logic        mc_start_o,
  input logic [1:0]  cu_state_o,
  input logic        cx_flag_o,
  input logic        irq_o
);
  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_req_active_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> cu_state_o == 2'd2);

  assert_state_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cu_state_o != 2'd3);

  assert_strobe_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_o || mc_start_o) |=> !(tx_start_o || mc_start_o));

  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_start_o && mc_start_o));

  assert_irq_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cx_flag_o);

  assert_irq_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

bind clw_cmd_walker clw_cmd_walker_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .tx_start_o  (tx_start_o),
  .mc_start_o  (mc_start_o),
  .cu_state_o  (cu_state_o),
  .cx_flag_o   (cx_flag_o),
  .irq_o       (irq_o)
);

// File: tb/clw_cmd_walker_tb_top.sv
module clw_cmd_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCFG = 14;
  localparam int NIA  = 6;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [15:0] data;
  } xact_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] head_ptr = '0;
  logic link_up = 1'b1;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic tx_start, mc_start, done;
  logic [31:0] blk_ptr;
  logic [8*NIA-1:0] ia;
  logic [8*NCFG-1:0] cfg;
  logic [1:0] cu_state;
  logic cx_flag, irq;

  int n_checks = 0;
  int n_errors = 0;
  logic [15:0] mem [0:2047];
  xact_t exp_q[$];
  logic [32:0] hs_q[$];
  int irq_cnt, tx_cnt, mc_cnt;

  logic [31:0] m_ptr = 32'hFFFF_FFFF;
  int m_cu = 0;
  bit m_cx = 0;
  int m_irq, m_tx, m_mc;
  logic [7:0] m_ia [NIA];
  logic [7:0] m_cfg [NCFG];

  always #(CLK_PERIOD/2) clk = ~clk;

  clw_cmd_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .head_ptr_i(head_ptr),
    .link_up_i(link_up), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ack_i(mem_ack), .tx_start_o(tx_start), .mc_start_o(mc_start),
    .blk_ptr_o(blk_ptr), .xfer_done_i(done), .ia_o(ia), .cfg_o(cfg),
    .cu_state_o(cu_state), .cx_flag_o(cx_flag), .irq_o(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input logic [31:0] a);
    return mem[a[11:1]];
  endfunction

  function automatic bit is_null(input logic [31:0] p);
    return p == 32'h0 || p == 32'hFFFF_FFFF;
  endfunction

  task automatic push(input logic we, input logic [31:0] a, input logic [15:0] d);
    xact_t x;
    x.we = we; x.addr = a; x.data = d;
    exp_q.push_back(x);
  endtask

  task automatic put_blk(input logic [31:0] a, input logic [15:0] cmd, input logic [31:0] link);
    mem[a[11:1]]       = 16'h0;
    mem[a[11:1] + 1]   = cmd;
    mem[a[11:1] + 2]   = link[15:0];
    mem[a[11:1] + 3]   = link[31:16];
  endtask

  task automatic put_w(input logic [31:0] a, input logic [15:0] d);
    mem[a[11:1]] = d;
  endtask

  // Behavioural model of one start pulse
  task automatic model_start(input logic [31:0] head);
    logic [15:0] cmd, w;
    logic [31:0] nxt;
    int n;
    m_cu = 2;
    if (is_null(m_ptr)) m_ptr = head;
    forever begin
      if (is_null(m_ptr)) begin m_cu = 0; break; end
      push(1, m_ptr, 16'h4000);
      push(0, m_ptr + 2, 'x);
      cmd = rd(m_ptr + 2);
      case (cmd[2:0])
        3'd1: for (int j = 0; j < 3; j++) begin
          push(0, m_ptr + 8 + 2*j, 'x);
          w = rd(m_ptr + 8 + 2*j);
          m_ia[2*j] = w[7:0]; m_ia[2*j+1] = w[15:8];
        end
        3'd2: begin
          n = int'(rd(m_ptr + 8) & 16'h000F);
          if (n < 4) n = 4;
          if (n > NCFG) n = NCFG;
          for (int j = 0; j < (n + 1) / 2; j++) begin
            push(0, m_ptr + 8 + 2*j, 'x);
            w = rd(m_ptr + 8 + 2*j);
            if (2*j < n) m_cfg[2*j] = w[7:0];
            if (2*j + 1 < n) m_cfg[2*j+1] = w[15:8];
          end
          if (m_cfg[10] < 8'd5) m_cfg[10] = 8'd5;
          m_cfg[13] = m_cfg[13] | 8'h3F;
        end
        3'd5: begin
          push(1, m_ptr + 8, link_up ? 16'h8000 : 16'h0000);
          push(1, m_ptr + 10, 16'h0000);
        end
        3'd4: begin hs_q.push_back({1'b1, m_ptr}); m_tx++; end
        3'd3: begin hs_q.push_back({1'b0, m_ptr}); m_mc++; end
        default: ;
      endcase
      push(1, m_ptr, 16'hA000);
      push(0, m_ptr + 4, 'x);
      push(0, m_ptr + 6, 'x);
      nxt = {rd(m_ptr + 6), rd(m_ptr + 4)};
      m_ptr = (cmd[15] || nxt == 0) ? 32'hFFFF_FFFF : nxt;
      m_cx = cmd[13];
      if (cmd[13]) m_irq++;
      if (cmd[14]) begin m_cu = 1; break; end
    end
  endtask

  // Memory responder: every access compared against the model's sequence
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (rst_n && mem_req) begin
        xact_t x;
        if (exp_q.size() == 0) begin
          chk("R3", "unexpected access addr", {95'd0, mem_we, mem_addr}, 128'hFFFF);
        end else begin
          x = exp_q.pop_front();
          chk("R3", "access dir/addr", {95'd0, mem_we, mem_addr}, {95'd0, x.we, x.addr});
          if (x.we) chk("R3", "write data", {112'd0, mem_wdata}, {112'd0, x.data});
        end
        if (mem_we) mem[mem_addr[11:1]] = mem_wdata;
        else mem_rdata = mem[mem_addr[11:1]];
        mem_ack = 1'b1;
      end
    end
  end

  // Hand-off responder (R8)
  initial begin
    done = 1'b0;
    forever begin
      @(negedge clk);
      if (tx_start || mc_start) begin
        logic [32:0] h;
        if (tx_start) tx_cnt++; else mc_cnt++;
        if (hs_q.size() == 0) chk("R8", "unexpected strobe", {95'd0, tx_start, blk_ptr}, '1);
        else begin
          h = hs_q.pop_front();
          chk("R8", "strobe kind/ptr", {95'd0, tx_start, blk_ptr}, {95'd0, h});
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (irq) irq_cnt++;
  end

  task automatic check_state(input string tag);
    logic [8*NIA-1:0]  e_ia;
    logic [8*NCFG-1:0] e_cfg;
    for (int k = 0; k < NIA; k++) e_ia[8*k +: 8] = m_ia[k];
    for (int k = 0; k < NCFG; k++) e_cfg[8*k +: 8] = m_cfg[k];
    chk(tag, "unit state", {126'd0, cu_state}, 128'(m_cu));
    chk("R11", "event flag", {127'd0, cx_flag}, {127'd0, m_cx});
    chk("R11", "irq pulses", 128'(irq_cnt), 128'(m_irq));
    chk("R8", "tx strobes", 128'(tx_cnt), 128'(m_tx));
    chk("R8", "mc strobes", 128'(mc_cnt), 128'(m_mc));
    chk("R4", "station address", {80'd0, ia}, {80'd0, e_ia});
    chk("R5", "config array", {16'd0, cfg}, {16'd0, e_cfg});
    chk("R3", "pending accesses", 128'(exp_q.size()), 128'd0);
  endtask

  task automatic run_walk(input logic [31:0] head, input bit poke, input string tag);
    int t;
    irq_cnt = 0; tx_cnt = 0; mc_cnt = 0;
    m_irq = 0; m_tx = 0; m_mc = 0;
    model_start(head);
    @(negedge clk);
    head_ptr = head; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin  // R12: start during a walk is ignored
      repeat (10) @(negedge clk);
      head_ptr = 32'h600; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (cu_state == 2'd2 && t < 5000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    check_state(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0;
    for (int k = 0; k < NIA; k++) m_ia[k] = 8'h0;
    for (int k = 0; k < NCFG; k++) m_cfg[k] = 8'h0;
    irq_cnt = 0; tx_cnt = 0; mc_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "unit state", {126'd0, cu_state}, 128'd0);
    chk("R1", "flag/irq/strobes/req",
        {123'd0, cx_flag, irq, tx_start, mc_start, mem_req}, 128'd0);
    chk("R1", "arrays", {16'd0, cfg}, 128'd0);
    chk("R1", "address", {80'd0, ia}, 128'd0);

    // Chain A: R3 R4 R5 R6 R7 R8 R9 R11 R12(poke)
    put_blk(32'h100, 16'h2000, 32'h140);
    put_blk(32'h140, 16'h0001, 32'h180);
    put_w(32'h148, 16'h2211); put_w(32'h14A, 16'h4433); put_w(32'h14C, 16'h6655);
    put_blk(32'h180, 16'h0002, 32'h1C0);
    put_w(32'h188, 16'hA502); put_w(32'h18A, 16'h3C7E); put_w(32'h18C, 16'hFFFF);
    put_blk(32'h1C0, 16'h0005, 32'h200);
    put_blk(32'h200, 16'h0004, 32'h240);
    put_blk(32'h240, 16'h0003, 32'h280);
    put_blk(32'h280, 16'hA006, 32'h2C0);
    link_up = 1'b1;
    run_walk(32'h100, 1'b1, "R9");
    chk("R7", "link word up", {112'd0, mem[12'h1C8 >> 1]}, 128'h8000);

    // Chain B: clamp to array size, fix-ups, link down, zero link ends
    put_blk(32'h300, 16'h0002, 32'h340);
    put_w(32'h308, 16'h110F); put_w(32'h30A, 16'h3322); put_w(32'h30C, 16'h5544);
    put_w(32'h30E, 16'h7766); put_w(32'h310, 16'h9988); put_w(32'h312, 16'hBB02);
    put_w(32'h314, 16'h40CC);
    put_blk(32'h340, 16'h2005, 32'h380);
    put_w(32'h348, 16'h1234);
    put_blk(32'h380, 16'h0007, 32'h0);
    link_up = 1'b0;
    run_walk(32'h300, 1'b0, "R9");
    chk("R6", "entry 10 raised", {120'd0, cfg[8*10 +: 8]}, 128'h05);
    chk("R6", "entry 13 ones", {120'd0, cfg[8*13 +: 8]}, 128'h7F);
    chk("R7", "link word down", {112'd0, mem[12'h348 >> 1]}, 128'h0);

    // Chain C: suspend then resume at saved link (R10)
    put_blk(32'h400, 16'h4000, 32'h440);
    put_blk(32'h440, 16'h2001, 32'hFFFF_FFFF);
    put_w(32'h448, 16'hBEEF); put_w(32'h44A, 16'hCAFE); put_w(32'h44C, 16'h0102);
    run_walk(32'h400, 1'b0, "R10");
    chk("R10", "suspended code", {126'd0, cu_state}, 128'd1);
    run_walk(32'h700, 1'b0, "R10");
    chk("R10", "idle after resume", {126'd0, cu_state}, 128'd0);

    // Null head: no accesses (R12)
    run_walk(32'h0, 1'b0, "R12");

    // Chain D: odd count in range, higher entries kept (R5)
    put_blk(32'h500, 16'h8002, 32'h540);
    put_w(32'h508, 16'h2205); put_w(32'h50A, 16'h4433); put_w(32'h50C, 16'h6655);
    run_walk(32'h500, 1'b0, "R5");
    chk("R5", "entry 5 kept", {120'd0, cfg[8*5 +: 8]}, 128'h55);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule